// File: doc/BRIEF.md
# Key-Sequenced 64-bit Watchdog Timer

This peripheral guards a system against software that stops responding. A 64-bit up-counter is compared against a 64-bit timeout period. Both values are split into two 32-bit halves on a small register bus with address, write enable, write data and a combinational read-data path. Software first sets up the period, the run mode and the half-release bits. It then arms the watchdog by writing two key values in a fixed order to the watchdog control register.

After arming, software keeps the system alive by repeating the two-key sequence before the count reaches the period. Each completed sequence restarts the count from zero. If the count reaches the period while the watchdog is live, the block raises a sticky timeout flag and emits a single-cycle reset request.

As soon as the first key has been accepted with the enable bit set, the whole timer configuration is frozen. Only the key field of the watchdog control register stays writable after that point.

Top module: `keyed_wdt`

## Requirements
- R1: After reset, every register reads zero except the identification word at 0x00, `rst_req` is low and the timeout flag is clear.
- R2: Register map: 0x00 identification (read-only), 0x04 reads zero, 0x10 and 0x14 are the low and high count halves, 0x18 and 0x1C are the low and high period halves, 0x20 is timer control with only bits 7:6 (run mode) implemented, 0x24 is global control with only bits 3:0 implemented, and 0x28 is watchdog control. While unlocked, writes to 0x10 through 0x24 read back as written within the implemented bits.
- R3: The count advances by one per clock only when global control bit 0 and bit 1 are both 1, global control bits 3:2 equal 2, and the run mode is nonzero. The count registers read the live 64-bit count, with carry into the high half. A count-half write takes precedence over the increment for that half.
- R4: Watchdog control bits 31:16 hold the key. Writing key 0xA5C6 with bit 14 set from the idle state enters pre-active, after which bit 14 reads 1. A following write of key 0xDA7E makes the watchdog live and restarts the count at zero.
- R5: From pre-active onward, writes to the count, period, timer control and global control registers, and to the non-key bits of watchdog control, have no effect.
- R6: Key writes out of order are ignored and leave the state unchanged. This covers 0xDA7E while idle or live, 0xA5C6 without bit 14 while idle, 0xA5C6 while pre-active, and any other key value.
- R7: While live, writing 0xA5C6 and then 0xDA7E services the watchdog, and the count restarts at zero on the second key.
- R8: In the cycle where the count equals the period while live, the block sets the timeout flag (watchdog control bit 15) and, one clock later, drives `rst_req` high for exactly one cycle. The flag then holds until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| rst_req | output | 1 | Single-cycle reset request on timeout |
| to_flag | output | 1 | Sticky timeout flag |

## Verification
The assertions assume that each bus write lasts one cycle and that the key field is the only way to change the arming state. They also assume that once locked, the configuration can change only through reset. The stimulus therefore holds `bus_we` for a single clock per access and keeps reset low for several cycles. It programs a small period before arming, so that a real timeout falls inside the run. Servicing is spaced well below that period, so that timeout and service never share a cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned REG_W = 32;
  localparam int unsigned KEY_W = 16;
  localparam int unsigned KEY_LSB = 16;
  localparam int unsigned EN_BIT = 14;
  localparam int unsigned FLAG_BIT = 15;

  localparam logic [KEY_W-1:0] KEY_OPEN  = 16'hA5C6;
  localparam logic [KEY_W-1:0] KEY_CLOSE = 16'hDA7E;

  localparam logic [7:0] A_ID     = 8'h00;
  localparam logic [7:0] A_EMU    = 8'h04;
  localparam logic [7:0] A_CNT_LO = 8'h10;
  localparam logic [7:0] A_CNT_HI = 8'h14;
  localparam logic [7:0] A_PRD_LO = 8'h18;
  localparam logic [7:0] A_PRD_HI = 8'h1C;
  localparam logic [7:0] A_TCTL   = 8'h20;
  localparam logic [7:0] A_GCTL   = 8'h24;
  localparam logic [7:0] A_WCTL   = 8'h28;

  typedef enum logic [1:0] {WD_IDLE, WD_PRE, WD_LIVE, WD_SVC} wd_state_e;

  // Counter runs only with both halves released, watchdog mode, nonzero run mode
  function automatic logic count_enabled(logic [1:0] mode, logic [3:0] gctl);
    return gctl[0] && gctl[1] && (gctl[3:2] == 2'd2) && (mode != 2'd0);
  endfunction

  // One key write applied to the arming state
  function automatic wd_state_e key_step(wd_state_e cur, logic [KEY_W-1:0] key, logic en);
    wd_state_e nxt;
    nxt = cur;
    case (cur)
      WD_IDLE: if (key == KEY_OPEN && en) nxt = WD_PRE;
      WD_PRE:  if (key == KEY_CLOSE)      nxt = WD_LIVE;
      WD_LIVE: if (key == KEY_OPEN)       nxt = WD_SVC;
      WD_SVC:  if (key == KEY_CLOSE)      nxt = WD_LIVE;
      default: nxt = cur;
    endcase
    return nxt;
  endfunction
endpackage

// File: rtl/wdt_keyfsm.sv
module wdt_keyfsm
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_wr,
  input  logic [KEY_W-1:0] key,
  input  logic             en_bit,
  output logic             locked,
  output logic             live,
  output logic             restart
);
  wd_state_e st_q;
  wd_state_e st_d;

  always_comb st_d = key_wr ? key_step(st_q, key, en_bit) : st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= WD_IDLE;
    else        st_q <= st_d;
  end

  assign locked  = (st_q != WD_IDLE);
  assign live    = (st_q == WD_LIVE) || (st_q == WD_SVC);
  // entering the live state (activation or completed service) restarts the count
  assign restart = (st_d == WD_LIVE) && (st_q != WD_LIVE);
endmodule

// File: rtl/wdt_count64.sv
module wdt_count64 #(
  parameter int unsigned HALF_W = 32,
  localparam int unsigned CNT_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              restart,
  input  logic              live,
  input  logic [1:0]        half_wr,
  input  logic [HALF_W-1:0] wdata,
  input  logic [CNT_W-1:0]  period,
  output logic [CNT_W-1:0]  cnt,
  output logic              hit,
  output logic              rst_req,
  output logic              flag
);
  logic [CNT_W-1:0] cnt_q;
  logic             hit_q;
  logic             req_q;
  logic             flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= run ? cnt_q + CNT_W'(1) : cnt_q;
      for (int h = 0; h < 2; h++) begin
        if (half_wr[h]) cnt_q[h*HALF_W +: HALF_W] <= wdata;
      end
    end
  end

  assign hit = live && (cnt_q == period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q  <= 1'b0;
      req_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      hit_q  <= hit;
      req_q  <= hit && !hit_q;
      flag_q <= flag_q || hit;
    end
  end

  assign cnt     = cnt_q;
  assign rst_req = req_q;
  assign flag    = flag_q;
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import wdt_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter logic [31:0] ID_VALUE = 32'h0057_D001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              rst_req,
  output logic              to_flag
);
  localparam int unsigned CNT_W = 2 * REG_W;

  logic             locked;
  logic             live;
  logic             cnt_restart;
  logic             cfg_we;
  logic             wctl_we;
  logic             run;
  logic             hit;
  logic [1:0]       cnt_half_wr;
  logic [1:0]       tctl_mode;
  logic [3:0]       gctl_q;
  logic [CNT_W-1:0] period_full;
  logic [CNT_W-1:0] cnt;

  assign cfg_we  = bus_we && !locked;
  assign wctl_we = bus_we && (bus_addr == ADDR_W'(A_WCTL));

  wdt_keyfsm u_keys (
    .clk     (clk),
    .rst_n   (rst_n),
    .key_wr  (wctl_we),
    .key     (bus_wdata[KEY_LSB +: KEY_W]),
    .en_bit  (bus_wdata[EN_BIT]),
    .locked  (locked),
    .live    (live),
    .restart (cnt_restart)
  );

  // period halves: identical registers at consecutive word addresses
  for (genvar h = 0; h < 2; h++) begin : g_prd
    localparam logic [ADDR_W-1:0] PRD_ADDR = ADDR_W'(A_PRD_LO) + ADDR_W'(4 * h);
    localparam logic [ADDR_W-1:0] CNT_ADDR = ADDR_W'(A_CNT_LO) + ADDR_W'(4 * h);
    logic [REG_W-1:0] half_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             half_q <= '0;
      else if (cfg_we && bus_addr == PRD_ADDR) half_q <= bus_wdata;
    end
    assign period_full[h*REG_W +: REG_W] = half_q;
    assign cnt_half_wr[h] = cfg_we && (bus_addr == CNT_ADDR);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tctl_mode <= 2'd0;
      gctl_q    <= 4'd0;
    end else if (cfg_we) begin
      if (bus_addr == ADDR_W'(A_TCTL)) tctl_mode <= bus_wdata[7:6];
      if (bus_addr == ADDR_W'(A_GCTL)) gctl_q    <= bus_wdata[3:0];
    end
  end

  assign run = count_enabled(tctl_mode, gctl_q);

  wdt_count64 #(.HALF_W(REG_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .restart (cnt_restart),
    .live    (live),
    .half_wr (cnt_half_wr),
    .wdata   (bus_wdata),
    .period  (period_full),
    .cnt     (cnt),
    .hit     (hit),
    .rst_req (rst_req),
    .flag    (to_flag)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(A_ID):     bus_rdata = ID_VALUE;
      ADDR_W'(A_EMU):    bus_rdata = '0;
      ADDR_W'(A_CNT_LO): bus_rdata = cnt[REG_W-1:0];
      ADDR_W'(A_CNT_HI): bus_rdata = cnt[CNT_W-1:REG_W];
      ADDR_W'(A_PRD_LO): bus_rdata = period_full[REG_W-1:0];
      ADDR_W'(A_PRD_HI): bus_rdata = period_full[CNT_W-1:REG_W];
      ADDR_W'(A_TCTL):   bus_rdata = {24'd0, tctl_mode, 6'd0};
      ADDR_W'(A_GCTL):   bus_rdata = {28'd0, gctl_q};
      ADDR_W'(A_WCTL):   bus_rdata = {16'd0, to_flag, locked, 14'd0};
      default:           bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/keyed_wdt_chk.sv
module keyed_wdt_chk #(
  parameter int unsigned CW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rst_req,
  input logic          flag,
  input logic          locked,
  input logic          live,
  input logic          restart,
  input logic          hit,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] period,
  input logic [1:0]    mode
);
  // R8
  req_single_chk: assert property (@(posedge clk) disable iff (!rst_n) rst_req |=> !rst_req);
  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) flag |=> flag);
  // R8
  req_has_flag_chk: assert property (@(posedge clk) disable iff (!rst_n) rst_req |-> flag);
  // R8
  hit_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n) hit |=> flag);
  // R8
  req_after_live_chk: assert property (@(posedge clk) disable iff (!rst_n) rst_req |-> $past(live));
  // R5
  period_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n) locked |=> $stable(period));
  // R5
  mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n) locked |=> $stable(mode));
  // R4
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) locked |=> locked);
  // R7
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) restart |=> (cnt == '0));
endmodule

bind keyed_wdt keyed_wdt_chk #(.CW(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .rst_req (rst_req),
  .flag    (to_flag),
  .locked  (locked),
  .live    (live),
  .restart (cnt_restart),
  .hit     (hit),
  .cnt     (cnt),
  .period  (period_full),
  .mode    (tctl_mode)
);

// File: tb/keyed_wdt_tb.sv
module keyed_wdt_tb;
  localparam logic [31:0] TB_ID = 32'h1234_5678;
  localparam logic [15:0] K1 = 16'hA5C6;
  localparam logic [15:0] K2 = 16'hDA7E;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        rst_req;
  logic        to_flag;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  keyed_wdt #(.ADDR_W(8), .ID_VALUE(TB_ID)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_req(rst_req), .to_flag(to_flag)
  );

  // ---------------- behavioural reference model ----------------
  int              m_state;   // 0 idle, 1 pre, 2 live, 3 service
  longint unsigned m_cnt, m_prd;
  int              m_mode, m_gctl;
  bit              m_flag, m_req, m_hitq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_cnt = 0; m_prd = 0; m_mode = 0; m_gctl = 0;
      m_flag = 0; m_req = 0; m_hitq = 0;
    end else begin
      bit              hit, runs, lk, rs;
      int              ns;
      longint unsigned nc;
      hit  = (m_state >= 2) && (m_cnt == m_prd);
      lk   = (m_state != 0);
      runs = (m_gctl % 4 == 3) && ((m_gctl / 4) == 2) && (m_mode != 0);
      ns = m_state; rs = 0;
      if (bus_we && bus_addr == 8'h28) begin
        if (m_state == 0 && bus_wdata[31:16] == K1 && bus_wdata[14]) ns = 1;
        else if (m_state == 1 && bus_wdata[31:16] == K2) begin ns = 2; rs = 1; end
        else if (m_state == 2 && bus_wdata[31:16] == K1) ns = 3;
        else if (m_state == 3 && bus_wdata[31:16] == K2) begin ns = 2; rs = 1; end
      end
      nc = runs ? m_cnt + 1 : m_cnt;
      if (bus_we && !lk) begin
        case (bus_addr)
          8'h10: nc = {nc[63:32], bus_wdata};
          8'h14: nc = {bus_wdata, nc[31:0]};
          8'h18: m_prd = {m_prd[63:32], bus_wdata};
          8'h1C: m_prd = {bus_wdata, m_prd[31:0]};
          8'h20: m_mode = int'(bus_wdata[7:6]);
          8'h24: m_gctl = int'(bus_wdata[3:0]);
          default: ;
        endcase
      end
      if (rs) nc = 0;
      m_req   = hit && !m_hitq;
      m_hitq  = hit;
      m_flag  = m_flag || hit;
      m_cnt   = nc;
      m_state = ns;
    end
  end

  function automatic logic [31:0] exp_rd(logic [7:0] a);
    case (a)
      8'h00: return TB_ID;
      8'h10: return m_cnt[31:0];
      8'h14: return m_cnt[63:32];
      8'h18: return m_prd[31:0];
      8'h1C: return m_prd[63:32];
      8'h20: return 32'(m_mode) << 6;
      8'h24: return 32'(m_gctl);
      8'h28: return {16'h0, m_flag, (m_state != 0), 14'h0};
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(string tag, longint unsigned act, longint unsigned exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // cycle-by-cycle comparison, away from the clock edge
  always begin
    @(negedge clk);
    #2;
    chk("R2 model read data", bus_rdata, exp_rd(bus_addr));
    chk("R8 model rst_req", rst_req, m_req);
    chk("R8 model flag", to_flag, m_flag);
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = 32'h0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    #2;
    d = bus_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, a, b;
    int pulses;
    logic [31:0] cnt_at;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h00, v); chk("R1 id", v, TB_ID);
    rd(8'h10, v); chk("R1 count lo", v, 0);
    rd(8'h18, v); chk("R1 period lo", v, 0);
    rd(8'h28, v); chk("R1 wctl", v, 0);
    chk("R1 rst_req", rst_req, 0);
    chk("R1 flag", to_flag, 0);

    // R2 map and readback
    wr(8'h18, 32'h1111_2222); rd(8'h18, v); chk("R2 period lo", v, 32'h1111_2222);
    wr(8'h1C, 32'h3333_4444); rd(8'h1C, v); chk("R2 period hi", v, 32'h3333_4444);
    wr(8'h20, 32'hFFFF_FFFF); rd(8'h20, v); chk("R2 tctl bits", v, 32'hC0);
    wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, v); chk("R2 emu zero", v, 0);
    wr(8'h20, 32'h80);
    wr(8'h24, 32'h9);         rd(8'h24, v); chk("R2 gctl", v, 32'h9);

    // R3 no count with high half held in reset
    wr(8'h10, 32'd5); repeat (4) @(negedge clk);
    rd(8'h10, v); chk("R3 held count", v, 5);
    wr(8'h24, 32'hB);
    rd(8'h10, a); repeat (9) @(negedge clk); rd(8'h10, b);
    chk("R3 running delta", b - a, 10);
    wr(8'h20, 32'h0);
    rd(8'h10, a); repeat (9) @(negedge clk); rd(8'h10, b);
    chk("R3 mode off stops", b - a, 0);
    wr(8'h20, 32'h40);
    rd(8'h10, a); repeat (9) @(negedge clk); rd(8'h10, b);
    chk("R3 one-shot mode runs", b - a, 10);
    wr(8'h14, 32'h0); wr(8'h10, 32'hFFFF_FFFE);
    repeat (3) @(negedge clk);
    rd(8'h14, v); chk("R3 carry into high", v, 1);
    wr(8'h14, 32'h0);

    // R6 out-of-order keys in idle
    wr(8'h28, {K2, 16'h4000}); rd(8'h28, v); chk("R6 close key idle", v, 0);
    wr(8'h28, {K1, 16'h0000}); rd(8'h28, v); chk("R6 open without enable", v, 0);
    wr(8'h28, {16'h1234, 16'h4000}); rd(8'h28, v); chk("R6 bad key idle", v, 0);
    wr(8'h18, 32'd60); rd(8'h18, v); chk("R6 still unlocked", v, 60);
    wr(8'h1C, 32'd0);

    // R4 arm, R5 lock
    wr(8'h28, {K1, 16'h4000}); rd(8'h28, v); chk("R4 pre-active", v, 32'h4000);
    wr(8'h18, 32'd7);   rd(8'h18, v); chk("R5 period locked", v, 60);
    wr(8'h20, 32'h0);   rd(8'h20, v); chk("R5 tctl locked", v, 32'h40);
    wr(8'h24, 32'h0);   rd(8'h24, v); chk("R5 gctl locked", v, 32'hB);
    wr(8'h28, 32'h0000_8000); rd(8'h28, v); chk("R5 wctl bits locked", v, 32'h4000);
    wr(8'h28, {16'h1234, 16'h4000});
    wr(8'h28, {K1, 16'h4000});
    wr(8'h28, {K2, 16'h0000});
    rd(8'h10, v); chk("R4 activation restart", v, 1);
    rd(8'h14, v); chk("R4 high half cleared", v, 0);

    // R7 service
    repeat (20) @(negedge clk);
    wr(8'h28, {K1, 16'h0});
    wr(8'h28, {K2, 16'h0});
    rd(8'h10, v); chk("R7 service restart", v, 1);

    // R6 close key without open while live
    repeat (10) @(negedge clk);
    rd(8'h10, a);
    wr(8'h28, {K2, 16'h0});
    rd(8'h10, b);
    chk("R6 lone close key live", b - a, 3);

    // R8 timeout
    pulses = 0; cnt_at = 0;
    @(negedge clk); bus_addr = 8'h10;
    for (int i = 0; i < 120; i++) begin
      @(negedge clk); #2;
      if (rst_req) begin pulses++; cnt_at = bus_rdata; end
    end
    chk("R8 single pulse", pulses, 1);
    chk("R8 count at pulse", cnt_at, 61);
    chk("R8 flag pin", to_flag, 1);
    rd(8'h28, v); chk("R8 flag bit", v, 32'hC000);
    wr(8'h28, 32'h0000_8000); rd(8'h28, v); chk("R8 flag held", v, 32'hC000);

    // R1 reset clears everything
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    rd(8'h28, v); chk("R1 wctl after reset", v, 0);
    chk("R1 flag after reset", to_flag, 0);
    rd(8'h18, v); chk("R1 period after reset", v, 0);

    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule